// File: doc/BRIEF.md
# Translation Lookaside Buffer with Fused Permission Check

This block is a small, fully associative cache of address translations. It sits between an address source and the memory system. A requester presents a virtual address together with the access kind (read or write) and the privilege level (kernel or user). In the same cycle the block answers with exactly one result: a translated physical address, a miss, a protection fault, or a request to set the page's dirty state. Every slot holds either a 4 KiB page or a 4 MiB page, and a per-slot size flag decides how many tag bits take part in the match.

On a miss, an outside page-table walker fetches the translation and writes it in through the refill port. A refill for a page that is already cached replaces that slot in place. Any other refill goes to the slot chosen by a round-robin pointer. A single flush input empties the whole structure at one clock edge. The walker, address-space tagging and the data cache are outside this block.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every slot is invalid, so any lookup reports a miss.
- R2: A lookup that hits a 4 KiB slot (virtual bits 31:12 equal to the stored tag) returns, in the same cycle, a physical address made of the stored frame number above virtual bits 11:0.
- R3: A 4 MiB slot compares only virtual bits 31:22. Its physical address is frame-number bits 19:10 (physical bits 31:22) above virtual bits 21:0. Stored frame bits 9:0 and tag bits 9:0 are ignored.
- R4: While a request is valid, exactly one of hit, miss, fault and dirty request is high. While no request is valid, all four are low. A lookup that matches no valid slot reports a miss.
- R5: A read needs the slot's read-permit bit and a write needs its write-permit bit. A user-mode access also needs the slot's user bit, while kernel mode ignores the user bit. A violation raises the fault output and no address.
- R6: A permitted write to a slot whose dirty bit is clear raises the dirty request instead of a hit. A read of such a slot hits, and a fault takes priority over a dirty request.
- R7: Refills that create a new slot fill slots in round-robin order starting at slot 0 after reset. The pointer moves by one only on such refills, so the ninth new page evicts the first.
- R8: A refill whose address matches an existing valid slot overwrites that slot and leaves the round-robin pointer unchanged.
- R9: Flush invalidates every slot at the next clock edge, and a refill presented in the same cycle as flush is dropped.
- R10: The physical-address output is zero whenever the hit output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| flush | input | 1 | Invalidate all slots |
| fill_valid | input | 1 | Refill strobe from the walker |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_ppn | input | 20 | Physical frame number of the refill |
| fill_large | input | 1 | 1 = 4 MiB page, 0 = 4 KiB page |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| fill_usr | input | 1 | User access permitted |
| fill_dirty | input | 1 | Page already marked dirty |
| rsp_hit | output | 1 | Translation granted |
| rsp_pa | output | 32 | Translated physical address (zero when no hit) |
| rsp_miss | output | 1 | No valid slot matches |
| rsp_prot_fault | output | 1 | Access denied by permissions |
| rsp_dirty_req | output | 1 | Write to a clean page needs its dirty bit set |

## Verification
The assertions check on every cycle that the four result outputs are mutually exclusive and complete, and that the page offset passes through on a hit. They also check that the address is zero without a hit, that no two slots match one address, that a flush leaves nothing to hit, and that the round-robin pointer steps only on new-slot refills. Only the bench scenarios can show which slot a refill evicts, that a repeated refill updates in place, that large pages ignore their low tag and frame bits, and how each mix of mode, access kind and permission bits maps to fault, dirty request or hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W     = 32;
  parameter int PA_W     = 32;
  parameter int PG_SHIFT = 12;
  parameter int LG_SHIFT = 22;

  localparam int VPN_W   = VA_W - PG_SHIFT;
  localparam int PPN_W   = PA_W - PG_SHIFT;
  localparam int LG_SPAN = LG_SHIFT - PG_SHIFT;

  typedef struct packed {
    logic             vld;
    logic             big;
    logic             rd;
    logic             wr;
    logic             usr;
    logic             dty;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             load,
  input  tlb_ent_t         load_ent,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [VPN_W-1:0] fill_vpn,
  output tlb_ent_t         ent_q,
  output logic             look_hit,
  output logic             fill_hit
);

  tlb_ent_t ent_d;
  logic     ent_en;

  function automatic logic tag_eq(input tlb_ent_t e, input logic [VPN_W-1:0] v);
    if (e.big) return v[VPN_W-1:LG_SPAN] == e.vpn[VPN_W-1:LG_SPAN];
    else       return v == e.vpn;
  endfunction

  always_comb begin
    look_hit = ent_q.vld && tag_eq(ent_q, look_vpn);
    fill_hit = ent_q.vld && tag_eq(ent_q, fill_vpn);
  end

  always_comb begin
    ent_d  = ent_q;
    ent_en = clr_all || load;
    if (clr_all)   ent_d.vld = 1'b0;
    else if (load) ent_d = load_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= '0;
    else if (ent_en) ent_q <= ent_d;
  end

  // R9: a clear leaves this slot unable to match
  p_slot_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !look_hit);

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENT = 8,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);

  logic [IW-1:0] ptr_d;

  always_comb begin
    if (ptr == IW'(N_ENT - 1)) ptr_d = '0;
    else                       ptr_d = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_d;
  end

  // R7: pointer only moves on a refill that creates a new slot
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr != $past(ptr)));

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm (
  input  logic p_rd,
  input  logic p_wr,
  input  logic p_usr,
  input  logic p_dty,
  input  logic is_wr,
  input  logic is_usr,
  output logic deny,
  output logic want_dirty
);

  logic kind_ok;
  logic mode_ok;

  always_comb begin
    kind_ok    = is_wr ? p_wr : p_rd;
    mode_ok    = !is_usr || p_usr;
    deny       = !(kind_ok && mode_ok);
    want_dirty = is_wr && !p_dty;
  end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  input  logic             flush,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_large,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             fill_usr,
  input  logic             fill_dirty,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_miss,
  output logic             rsp_prot_fault,
  output logic             rsp_dirty_req
);

  localparam int IW = $clog2(N_ENT);

  tlb_ent_t         ent_q   [N_ENT];
  logic [N_ENT-1:0] look_vec;
  logic [N_ENT-1:0] fill_vec;
  logic [N_ENT-1:0] load_vec;
  tlb_ent_t         new_ent;
  logic             fill_go;
  logic             dup_any;
  logic [IW-1:0]    dup_idx;
  logic [IW-1:0]    vic_ptr;
  logic             vic_adv;

  logic             any_hit;
  logic             sel_big, sel_rd, sel_wr, sel_usr, sel_dty;
  logic [PPN_W-1:0] sel_ppn;
  logic             deny, want_dirty;
  logic [PA_W-1:0]  xl_pa;

  // refill record
  always_comb begin
    new_ent     = '0;
    new_ent.vld = 1'b1;
    new_ent.big = fill_large;
    new_ent.rd  = fill_rd;
    new_ent.wr  = fill_wr;
    new_ent.usr = fill_usr;
    new_ent.dty = fill_dirty;
    new_ent.vpn = fill_vpn;
    new_ent.ppn = fill_ppn;
  end

  // duplicate search: lowest matching slot wins
  always_comb begin
    dup_any = 1'b0;
    dup_idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (fill_vec[i] && !dup_any) begin
        dup_any = 1'b1;
        dup_idx = IW'(i);
      end
    end
  end

  always_comb begin
    fill_go = fill_valid && !flush;
    vic_adv = fill_go && !dup_any;
    for (int i = 0; i < N_ENT; i++) begin
      load_vec[i] = fill_go && (dup_any ? (dup_idx == IW'(i)) : (vic_ptr == IW'(i)));
    end
  end

  tlb_victim #(.N_ENT(N_ENT)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (vic_adv),
    .ptr   (vic_ptr)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    tlb_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (flush),
      .load     (load_vec[g]),
      .load_ent (new_ent),
      .look_vpn (req_va[VA_W-1:PG_SHIFT]),
      .fill_vpn (fill_vpn),
      .ent_q    (ent_q[g]),
      .look_hit (look_vec[g]),
      .fill_hit (fill_vec[g])
    );
  end

  // one-hot select of the matching slot's fields
  always_comb begin
    any_hit = |look_vec;
    sel_big = 1'b0;
    sel_rd  = 1'b0;
    sel_wr  = 1'b0;
    sel_usr = 1'b0;
    sel_dty = 1'b0;
    sel_ppn = '0;
    for (int i = 0; i < N_ENT; i++) begin
      sel_big |= look_vec[i] & ent_q[i].big;
      sel_rd  |= look_vec[i] & ent_q[i].rd;
      sel_wr  |= look_vec[i] & ent_q[i].wr;
      sel_usr |= look_vec[i] & ent_q[i].usr;
      sel_dty |= look_vec[i] & ent_q[i].dty;
      sel_ppn |= {PPN_W{look_vec[i]}} & ent_q[i].ppn;
    end
  end

  tlb_perm u_perm (
    .p_rd       (sel_rd),
    .p_wr       (sel_wr),
    .p_usr      (sel_usr),
    .p_dty      (sel_dty),
    .is_wr      (req_write),
    .is_usr     (req_user),
    .deny       (deny),
    .want_dirty (want_dirty)
  );

  always_comb begin
    if (sel_big) xl_pa = {sel_ppn[PPN_W-1:LG_SPAN], req_va[LG_SHIFT-1:0]};
    else         xl_pa = {sel_ppn, req_va[PG_SHIFT-1:0]};
  end

  always_comb begin
    rsp_miss       = req_valid && !any_hit;
    rsp_prot_fault = req_valid && any_hit && deny;
    rsp_dirty_req  = req_valid && any_hit && !deny && want_dirty;
    rsp_hit        = req_valid && any_hit && !deny && !want_dirty;
    rsp_pa         = rsp_hit ? xl_pa : '0;
  end

  // R4: exactly one outcome per valid request
  p_one_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({rsp_hit, rsp_miss, rsp_prot_fault, rsp_dirty_req}));
  // R4: quiet without a request
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ({rsp_hit, rsp_miss, rsp_prot_fault, rsp_dirty_req} == 4'b0000));
  // R2: page offset passes through untranslated
  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_pa[PG_SHIFT-1:0] == req_va[PG_SHIFT-1:0]));
  // R10: no address without a hit
  p_pa_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_pa == '0));
  // R8: refills never leave two slots matching one address
  p_no_double_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_vec));
  // R9: nothing can hit right after a flush
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!req_valid || rsp_miss));

endmodule

// File: tb/sim_xlat_tlb.sv
module sim_xlat_tlb;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_user, flush;
  logic [31:0] req_va;
  logic        fill_valid, fill_large, fill_rd, fill_wr, fill_usr, fill_dirty;
  logic [19:0] fill_vpn, fill_ppn;
  logic        rsp_hit, rsp_miss, rsp_prot_fault, rsp_dirty_req;
  logic [31:0] rsp_pa;

  always #(PER/2) clk = ~clk;

  xlat_tlb u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .flush(flush),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_large(fill_large), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .fill_usr(fill_usr), .fill_dirty(fill_dirty), .rsp_hit(rsp_hit),
    .rsp_pa(rsp_pa), .rsp_miss(rsp_miss), .rsp_prot_fault(rsp_prot_fault),
    .rsp_dirty_req(rsp_dirty_req)
  );

  typedef struct {
    logic [3:0]  res;   // {hit, miss, fault, dirty}
    logic [31:0] pa;
    string       tag;
  } exp_t;

  exp_t  sb_q[$];
  logic  chk_pend = 1'b0;
  int    n_chk = 0;
  int    n_err = 0;
  logic  done = 1'b0;

  localparam logic [3:0] E_HIT = 4'b1000, E_MISS = 4'b0100, E_FLT = 4'b0010, E_DRQ = 4'b0001;

  function automatic logic [31:0] small_pa(input logic [19:0] ppn, input logic [31:0] va);
    return {ppn, va[11:0]};
  endfunction

  task automatic quiet();
    req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_user = 1'b0;
    flush = 1'b0; fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0;
    fill_large = 1'b0; fill_rd = 1'b0; fill_wr = 1'b0; fill_usr = 1'b0; fill_dirty = 1'b0;
  endtask

  task automatic look(input logic rv, input logic [31:0] va, input logic w, input logic u,
                      input logic [3:0] eres, input logic [31:0] epa, input string tag);
    exp_t e;
    @(negedge clk);
    quiet();
    req_valid = rv; req_va = va; req_write = w; req_user = u;
    e.res = eres; e.pa = (eres == E_HIT) ? epa : 32'h0; e.tag = tag;
    sb_q.push_back(e);
    chk_pend = 1'b1;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic lg,
                      input logic r, input logic w, input logic u, input logic d,
                      input logic fl);
    @(negedge clk);
    quiet();
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_large = lg;
    fill_rd = r; fill_wr = w; fill_usr = u; fill_dirty = d; flush = fl;
  endtask

  task automatic do_flush();
    @(negedge clk);
    quiet();
    flush = 1'b1;
  endtask

  // monitor: pop expected item and compare away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #(PER/4);
      if (chk_pend) begin
        exp_t e;
        logic [3:0] got;
        e = sb_q.pop_front();
        got = {rsp_hit, rsp_miss, rsp_prot_fault, rsp_dirty_req};
        n_chk++;
        if (got !== e.res || rsp_pa !== e.pa) begin
          n_err++;
          $display("FAIL %s: got res=%b pa=%h expected res=%b pa=%h",
                   e.tag, got, rsp_pa, e.res, e.pa);
        end
        chk_pend = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look(1, 32'h0010_0123, 0, 0, E_MISS, 0, "R1 reset miss");

    // R7: eight new pages fill slots 0..7
    for (int i = 0; i < 8; i++)
      fill(20'h00100 + 20'(i), 20'h0A000 + 20'(i), 0, 1, 1, 1, 1, 0);
    // R2: small-page hits
    for (int i = 0; i < 8; i++)
      look(1, 32'h0010_0000 + 32'(i << 12) + 32'h5A4, 0, 1, E_HIT,
           small_pa(20'h0A000 + 20'(i), 32'h5A4), "R2 small hit");
    look(1, 32'h0010_3FFF, 1, 1, E_HIT, small_pa(20'h0A003, 32'hFFF), "R2 write hit dirty page");
    look(1, 32'h0010_8000, 0, 0, E_MISS, 0, "R4 unmatched miss");

    // R4: no request, no outputs
    look(0, 32'h0010_1000, 0, 0, 4'b0000, 0, "R4 idle quiet");

    // R8: repeated page updates in place
    fill(20'h00100, 20'h0B000, 0, 1, 1, 1, 1, 0);
    look(1, 32'h0010_0ABC, 0, 0, E_HIT, small_pa(20'h0B000, 32'hABC), "R8 in-place update");

    // R7: ninth new page evicts slot 0, not slot 1
    fill(20'h00108, 20'h0A008, 0, 1, 1, 1, 1, 0);
    look(1, 32'h0010_0ABC, 0, 0, E_MISS, 0, "R7 oldest evicted");
    look(1, 32'h0010_1010, 0, 0, E_HIT, small_pa(20'h0A001, 32'h010), "R7/R8 slot1 kept");
    look(1, 32'h0010_8010, 0, 0, E_HIT, small_pa(20'h0A008, 32'h010), "R7 new page hit");

    // R9: flush empties; refill with flush is dropped
    do_flush();
    look(1, 32'h0010_8010, 0, 0, E_MISS, 0, "R9 flush clears");
    look(1, 32'h0010_2010, 0, 0, E_MISS, 0, "R9 flush clears other");
    fill(20'h00300, 20'h0C000, 0, 1, 1, 1, 1, 1);
    look(1, 32'h0030_0000, 0, 0, E_MISS, 0, "R9 fill dropped during flush");

    // R3: large page ignores low tag and frame bits
    fill(20'h40455, 20'h8C0AB, 1, 1, 1, 1, 1, 0);
    look(1, 32'h4073_4567, 0, 1, E_HIT, 32'h8C33_4567, "R3 large hit");
    look(1, 32'h4040_0000, 0, 1, E_HIT, 32'h8C00_0000, "R3 large base");
    look(1, 32'h407F_FFFF, 1, 1, E_HIT, 32'h8C3F_FFFF, "R3 large top");
    look(1, 32'h4083_0000, 0, 1, E_MISS, 0, "R3 outside large");

    // R5: kernel-only read-only page
    fill(20'h20000, 20'h30000, 0, 1, 0, 0, 1, 0);
    look(1, 32'h2000_0044, 0, 0, E_HIT, small_pa(20'h30000, 32'h044), "R5 kernel read ignores user bit");
    look(1, 32'h2000_0044, 0, 1, E_FLT, 0, "R5 user denied");
    look(1, 32'h2000_0044, 1, 0, E_FLT, 0, "R5 write to read-only");

    // R6: user writable clean page
    fill(20'h21000, 20'h31000, 0, 1, 1, 1, 0, 0);
    look(1, 32'h2100_0800, 0, 1, E_HIT, small_pa(20'h31000, 32'h800), "R6 read clean hits");
    look(1, 32'h2100_0800, 1, 1, E_DRQ, 0, "R6 write clean dirty req");
    look(1, 32'h2100_0800, 1, 0, E_DRQ, 0, "R6 kernel write clean dirty req");

    // R5: write-only user page
    fill(20'h22000, 20'h32000, 0, 0, 1, 1, 1, 0);
    look(1, 32'h2200_0010, 0, 1, E_FLT, 0, "R5 read without read bit");
    look(1, 32'h2200_0010, 1, 1, E_HIT, small_pa(20'h32000, 32'h010), "R5 write permitted");

    // R6: fault outranks dirty request
    fill(20'h23000, 20'h33000, 0, 1, 0, 1, 0, 0);
    look(1, 32'h2300_0020, 1, 1, E_FLT, 0, "R6 fault over dirty req");

    @(negedge clk);
    quiet();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule